// File: doc/BRIEF.md
# Multitap Console Port Responder

This block sits on the controller side of a retro console's 4-bit parallel pad port and answers for a five-player multitap. The console drives two strobes, a select strobe and a clear strobe, which reach this block already synchronized to its clock. Upstream logic presents one byte per player. The block drives the 4-bit active-low data bus. While the clear strobe is low, each player's byte is served as two nibbles, chosen by the select level, and the player index steps forward on every rising edge of select.

At the falling edge of the clear strobe, all player bytes are copied into a local snapshot. A scan therefore never mixes two generations of data, and a hold output tells upstream logic that the snapshot is in use. Every finished scan raises a one-cycle completion pulse and steps a two-bit scan-state counter down through 3, 2, 1, 0 and back to 3. Downstream formatters use this counter to pick multi-scan report phases. A watchdog ends a scan that stalls with clear low and select high. It then forces the state counter to 0.

Top module: `mtap_responder`

## Requirements
- R1: After reset, and whenever no scan is active, `data_o` reads 0xF, `hold_o` is 0 and `scan_done_o` is 0. The scan state resets to 3.
- R2: During a scan, `data_o` shows the current player's direction nibble `pad[7:4]` (bit4 Up, bit5 Right, bit6 Down, bit7 Left) while select is high. It shows the button nibble `pad[3:0]` (bit0 I, bit1 II, bit2 Select, bit3 Run) while select is low. All values are 0 for pressed. The output follows the inputs one clock later.
- R3: A falling clear strobe starts a scan at player 1. Each rising select edge during the scan moves to the next player. Player p+1 is taken from `pad_bytes_i[8p+7:8p]`. After the fifth player, the bus reads 0xF until the scan ends.
- R4: The player bytes are captured on the clock where clear is first seen low. Changes to `pad_bytes_i` during the scan do not reach `data_o`. `hold_o` stays high for the whole scan.
- R5: A rising clear strobe ends the scan. The bus returns to 0xF, `hold_o` drops and `scan_done_o` is high for exactly one clock.
- R6: Each scan that ends normally moves the scan state one step down. It goes from 0 back to 3. The state does not change at any other time, except on a timeout.
- R7: If clear stays low with select high for CLK_MHZ*TIMEOUT_US consecutive clocks, the scan ends. `scan_done_o` pulses, the state becomes 0 and the bus reads 0xF. The later rise of clear produces no further pulse.
- R8: Any clock with select low restarts the stall count, so a scan whose select keeps toggling never times out.
- R9: Select edges while clear is high have no effect. The bus stays 0xF, and the next scan still starts at player 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Synchronized select strobe from the console |
| clr_i | input | 1 | Synchronized clear strobe from the console (low = scan) |
| pad_bytes_i | input | 40 | Five player bytes, player 1 in the low byte |
| data_o | output | 4 | Active-low data nibble toward the console |
| hold_o | output | 1 | High while the snapshot is in use by a scan |
| scan_done_o | output | 1 | One-clock pulse when a scan ends or times out |
| scan_state_o | output | 2 | Descending per-scan state counter |

## Verification
The hardest situation to reach is the stall timeout. The scan has to sit for more than a thousand clocks with select held high and clear held low. The edge cases are the exact clock on which it fires and the one just before it, when a select-low clock rescues the scan. The stimulus drives a stalled scan and checks that it is still open one clock before the limit and closed on the limit. It then runs a separate scan that drops select for one clock every limit-minus-three clocks, across more than three limits, which must end normally. Sixteen full scans also sweep every nibble value through every player slot. Each scan corrupts the input bytes right after it starts, which exposes any leak past the snapshot.

// File: rtl/mtap_pkg.sv
package mtap_pkg;
    localparam int NIB_W   = 4;
    localparam int STATE_W = 2;

    typedef logic [NIB_W-1:0]   nib_t;
    typedef logic [STATE_W-1:0] sstate_t;

    localparam nib_t    NIB_IDLE   = '1;
    localparam sstate_t SSTATE_TOP = '1;

    // Descending scan phase with wrap from zero to the top value.
    function automatic sstate_t sstate_next(sstate_t s);
        return (s == '0) ? SSTATE_TOP : sstate_t'(s - 1'b1);
    endfunction
endpackage

// File: rtl/mtap_snapshot.sv
module mtap_snapshot #(
    parameter int NUM_PLAYERS = 5,
    parameter int BYTE_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [NUM_PLAYERS*BYTE_W-1:0] bytes_i,
    output logic [NUM_PLAYERS*BYTE_W-1:0] bytes_o
);
    for (genvar g = 0; g < NUM_PLAYERS; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = load_i ? bytes_i[g*BYTE_W +: BYTE_W] : slot_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '1;
            else        slot_q <= slot_d;
        end

        assign bytes_o[g*BYTE_W +: BYTE_W] = slot_q;
    end
endmodule

// File: rtl/mtap_watchdog.sv
module mtap_watchdog #(
    parameter int LIMIT = 1100,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
        cnt_d    = (run_i && !expire_o) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/mtap_nibble_mux.sv
module mtap_nibble_mux
    import mtap_pkg::*;
#(
    parameter int NUM_PLAYERS = 5,
    parameter int PIDX_W      = 3,
    localparam int BYTE_W     = 2 * NIB_W
) (
    input  logic                          active_i,
    input  logic                          upper_i,
    input  logic [PIDX_W-1:0]             pidx_i,
    input  logic [NUM_PLAYERS*BYTE_W-1:0] bytes_i,
    output nib_t                          nib_o
);
    always_comb begin
        nib_o = NIB_IDLE;
        if (active_i) begin
            for (int p = 0; p < NUM_PLAYERS; p++) begin
                if (pidx_i == PIDX_W'(p)) begin
                    nib_o = upper_i ? bytes_i[p*BYTE_W + NIB_W +: NIB_W]
                                    : bytes_i[p*BYTE_W +: NIB_W];
                end
            end
        end
    end
endmodule

// File: rtl/mtap_responder.sv
module mtap_responder
    import mtap_pkg::*;
#(
    parameter int NUM_PLAYERS = 5,
    parameter int CLK_MHZ     = 2,
    parameter int TIMEOUT_US  = 550
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_i,
    input  logic                        clr_i,
    input  logic [NUM_PLAYERS*8-1:0]    pad_bytes_i,
    output logic [3:0]                  data_o,
    output logic                        hold_o,
    output logic                        scan_done_o,
    output logic [1:0]                  scan_state_o
);
    localparam int BYTE_W  = 2 * NIB_W;
    localparam int PIDX_W  = $clog2(NUM_PLAYERS + 1);
    localparam int TMO_CYC = CLK_MHZ * TIMEOUT_US;
    localparam int CNT_W   = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic              clr;
        logic              sel;
        logic              active;
        logic [PIDX_W-1:0] pidx;
        sstate_t           sstate;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                          clr_fall, clr_rise, sel_rise;
    logic                          tmo_expire;
    logic [CNT_W-1:0]              wd_count;
    logic [NUM_PLAYERS*BYTE_W-1:0] snap_bytes;

    assign clr_fall = seq_q.clr & ~clr_i;
    assign clr_rise = ~seq_q.clr & clr_i;
    assign sel_rise = ~seq_q.sel & sel_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.clr  = clr_i;
        seq_d.sel  = sel_i;
        seq_d.done = 1'b0;
        if (clr_fall) begin
            seq_d.active = 1'b1;
            seq_d.pidx   = '0;
        end else if (seq_q.active) begin
            if (tmo_expire) begin
                seq_d.active = 1'b0;
                seq_d.sstate = '0;
                seq_d.done   = 1'b1;
            end else if (clr_rise) begin
                seq_d.active = 1'b0;
                seq_d.sstate = sstate_next(seq_q.sstate);
                seq_d.done   = 1'b1;
            end else if (sel_rise && (seq_q.pidx != PIDX_W'(NUM_PLAYERS))) begin
                seq_d.pidx = seq_q.pidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{clr: 1'b1, sel: 1'b1, active: 1'b0, pidx: '0,
                       sstate: SSTATE_TOP, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    mtap_snapshot #(
        .NUM_PLAYERS(NUM_PLAYERS),
        .BYTE_W     (BYTE_W)
    ) snap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (clr_fall),
        .bytes_i(pad_bytes_i),
        .bytes_o(snap_bytes)
    );

    mtap_watchdog #(
        .LIMIT(TMO_CYC)
    ) wdog_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (seq_q.active & ~seq_q.clr & seq_q.sel),
        .expire_o(tmo_expire),
        .count_o (wd_count)
    );

    mtap_nibble_mux #(
        .NUM_PLAYERS(NUM_PLAYERS),
        .PIDX_W     (PIDX_W)
    ) mux_i (
        .active_i(seq_q.active),
        .upper_i (seq_q.sel),
        .pidx_i  (seq_q.pidx),
        .bytes_i (snap_bytes),
        .nib_o   (data_o)
    );

    assign hold_o       = seq_q.active;
    assign scan_done_o  = seq_q.done;
    assign scan_state_o = seq_q.sstate;
endmodule

// File: rtl/mtap_responder_chk.sv
module mtap_responder_chk #(
    parameter int NUM_PLAYERS = 5,
    parameter int BYTE_W      = 8,
    parameter int TMO_CYC     = 1100,
    parameter int CNT_W       = 11
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clr_i,
    input logic [3:0]                    data_o,
    input logic                          hold_o,
    input logic                          scan_done_o,
    input logic [1:0]                    scan_state_o,
    input logic [CNT_W-1:0]              wd_count,
    input logic [NUM_PLAYERS*BYTE_W-1:0] snap
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |-> data_o == 4'hF);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);

    p_done_ends_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |-> (!hold_o && $past(hold_o)));

    p_state_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |-> (scan_state_o == 2'd0)
                     || (scan_state_o == 2'($past(scan_state_o) - 2'd1))
                     || ($past(scan_state_o) == 2'd0 && scan_state_o == 2'd3));

    p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done_o |-> $stable(scan_state_o));

    p_snap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && $past(hold_o)) |-> $stable(snap));

    p_wdog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_count < CNT_W'(TMO_CYC));

    p_clr_high_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> !hold_o);
endmodule

bind mtap_responder mtap_responder_chk #(
    .NUM_PLAYERS(NUM_PLAYERS),
    .BYTE_W     (BYTE_W),
    .TMO_CYC    (TMO_CYC),
    .CNT_W      (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .data_o      (data_o),
    .hold_o      (hold_o),
    .scan_done_o (scan_done_o),
    .scan_state_o(scan_state_o),
    .wd_count    (wd_count),
    .snap        (snap_bytes)
);

// File: tb/mtap_responder_tb.sv
module mtap_responder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 5;
    localparam int MHZ        = 2;
    localparam int TMO_US     = 550;
    localparam int LIMIT      = MHZ * TMO_US;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b1;
    logic          clr = 1'b1;
    logic [NP*8-1:0] pads = '0;
    logic [3:0]    data;
    logic          hold;
    logic          done;
    logic [1:0]    sstate;

    int n_chk  = 0;
    int n_fail = 0;
    int est    = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtap_responder #(
        .NUM_PLAYERS(NP),
        .CLK_MHZ    (MHZ),
        .TIMEOUT_US (TMO_US)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .clr_i       (clr),
        .pad_bytes_i (pads),
        .data_o      (data),
        .hold_o      (hold),
        .scan_done_o (done),
        .scan_state_o(sstate)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pad_of(int k, int p);
        return {4'(k + p), 4'(k + 3*p + 5)};
    endfunction

    // Full scan over all players, corrupting inputs right after the start.
    task automatic do_scan(input int k);
        logic [NP*8-1:0] orig;
        for (int p = 0; p < NP; p++) orig[p*8 +: 8] = pad_of(k, p);
        pads = orig;
        sel = 1'b1;
        clr = 1'b0;
        tick();
        pads = ~orig;
        check("R3 start dpad p1", int'(data), int'(orig[7:4]));
        check("R4 hold during scan", int'(hold), 1);
        for (int p = 0; p < NP; p++) begin
            sel = 1'b0;
            tick();
            check("R2 button nibble", int'(data), int'(orig[p*8 +: 4]));
            sel = 1'b1;
            tick();
            if (p < NP - 1)
                check("R2 dpad nibble", int'(data), int'(orig[(p+1)*8+4 +: 4]));
            else
                check("R3 past fifth idle", int'(data), 15);
        end
        clr = 1'b1;
        tick();
        est = (est == 0) ? 3 : est - 1;
        check("R5 end bus idle", int'(data), 15);
        check("R5 done pulse", int'(done), 1);
        check("R5 hold drop", int'(hold), 0);
        check("R6 state step", int'(sstate), est);
        tick();
        check("R5 done one cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1 reset bus", int'(data), 15);
        check("R1 reset hold", int'(hold), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset state", int'(sstate), 3);

        // R9: select activity with clear high
        for (int i = 0; i < 6; i++) begin
            sel = ~sel;
            tick();
            check("R9 idle bus", int'(data), 15);
            check("R9 idle hold", int'(hold), 0);
        end
        sel = 1'b1;
        tick();

        // R2/R3/R4/R5/R6: nibble sweep over all players
        for (int k = 0; k < 16; k++) do_scan(k);

        // R7: stalled scan
        pads = '0;
        sel = 1'b1;
        clr = 1'b0;
        tick();
        repeat (LIMIT - 1) tick();
        check("R7 still open before limit", int'(hold), 1);
        tick();
        check("R7 closed at limit", int'(hold), 0);
        check("R7 done pulse", int'(done), 1);
        check("R7 state forced", int'(sstate), 0);
        check("R7 bus idle", int'(data), 15);
        est = 0;
        tick();
        clr = 1'b1;
        tick();
        check("R7 no second pulse", int'(done), 0);
        check("R7 state kept", int'(sstate), 0);

        // R8: long scan kept alive by short select-low clocks
        clr = 1'b0;
        tick();
        for (int i = 0; i < 4; i++) begin
            repeat (LIMIT - 3) tick();
            sel = 1'b0;
            tick();
            sel = 1'b1;
            tick();
        end
        check("R8 scan survives", int'(hold), 1);
        clr = 1'b1;
        tick();
        check("R8 normal end", int'(done), 1);
        check("R6 wrap to three", int'(sstate), 3);
        est = 3;

        // R9: next scan after idle toggles starts at player 1
        do_scan(7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule